// File: doc/BRIEF.md
# Prioritised Vector Address Generator

This block executes the vector-select step of an interrupt controller. When the select strobe arrives it takes a snapshot of the sixteen active-request lines and picks the highest-ranked one. The choice is made at this moment, not when the interrupt was first taken, so a higher-ranked source that became active in the meantime wins. The block then looks up that source's slot in a 32-byte vector table and reads the two bytes of the slot over a byte-wide synchronous program-memory port. It joins them into a 15-bit service-routine address and presents that address as an indirect jump target, together with a one-cycle done strobe.

The table occupies the top 32 bytes of a 256-byte page. This is normally the page that holds the select instruction. When the instruction is the last byte of its page, the next page is used instead. The entry sequencer and the clearing of pending bits belong to the surrounding controller.

Top module: `vag_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `jump_vld` and `rd_en` are 0 and `jump_tgt` is 0.
- R2: `req_act[k]` is the request of rank k+1, and a lower index means a higher rank. Of bits 0 to 14, the lowest set index wins. Bit 0 is the software request and always wins when set.
- R3: When none of `req_act[14:0]` is set, rank 16 (index 15) is selected whatever the value of `req_act[15]`.
- R4: Requests and `sel_pc` are sampled only at the clock edge where an accepted `sel_go` is seen. Changes after that edge do not alter the addresses read or the target produced.
- R5: For winning index k, the high byte is read at in-page offset 0xFE − 2·k and the low byte at that offset + 1. The page is `sel_pc[14:8]`.
- R6: When `sel_pc[7:0]` is 0xFF, the table page is `sel_pc[14:8]` + 1, wrapping from 0x7F to 0x00.
- R7: The memory has one cycle of read latency. `rd_en` is high with the high-byte address in the cycle after the accepting edge, and with the low-byte address in the cycle after that. It is low otherwise.
- R8: `jump_tgt` equals {high byte bits 6:0, low byte}. Bit 7 of the high byte is discarded.
- R9: `jump_vld` is a one-cycle pulse. It is high in the third cycle after the last `rd_en` cycle's start, which is the fourth cycle after the accepting edge.
- R10: `sel_go` is ignored while a selection is in progress, that is until `jump_vld` has been raised. `jump_tgt` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_go | input | 1 | Execute the vector-select step |
| req_act | input | 16 | Active (enabled and pending) requests, index 0 highest rank |
| sel_pc | input | 15 | Address of the select instruction |
| rd_en | output | 1 | Program-memory read request |
| rd_addr | output | 15 | Program-memory read address |
| rd_data | input | 8 | Read data, valid one cycle after the address |
| jump_tgt | output | 15 | Service-routine address |
| jump_vld | output | 1 | Target is new this cycle |

## Verification
Counting from the edge that accepts `sel_go`, the high-byte address is due in the next cycle and the low-byte address in the cycle after. The third cycle carries no read and no strobe. The target and strobe appear in the fourth cycle, and the strobe is gone in the fifth. Each scenario task drives its inputs on a falling edge and then walks falling edge by falling edge through exactly these five cycles, checking the port values due in each one. The bench's memory model computes each byte from its address, so the expected target follows from the reference priority and page model alone.

// File: rtl/vag_pkg.sv
package vag_pkg;

    localparam int NRANK   = 16;
    localparam int RW      = $clog2(NRANK);
    localparam int AW      = 15;
    localparam int DW      = 8;
    localparam int OFFW    = 8;
    localparam int PW      = AW - OFFW;
    localparam logic [OFFW-1:0] TOP_SLOT = 8'hFE;
    localparam logic [OFFW-1:0] PAGE_END = 8'hFF;

    typedef logic [RW-1:0]   rank_t;
    typedef logic [PW-1:0]   page_t;
    typedef logic [AW-1:0]   addr_t;
    typedef logic [DW-1:0]   byte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_CAP
    } fetch_st_t;

    typedef struct packed {
        rank_t rank;
        page_t page;
    } pick_t;

    function automatic page_t table_page(input addr_t pc);
        if (pc[OFFW-1:0] == PAGE_END)
            return page_t'(pc[AW-1:OFFW] + 1'b1);
        return pc[AW-1:OFFW];
    endfunction

    function automatic logic [OFFW-1:0] slot_offset(input rank_t r);
        return TOP_SLOT - {{(OFFW-RW-1){1'b0}}, r, 1'b0};
    endfunction

    function automatic logic [NRANK-1:0] higher_mask(input rank_t r);
        logic [NRANK-1:0] m;
        for (int i = 0; i < NRANK; i++) m[i] = (i < int'(r));
        return m;
    endfunction

endpackage

// File: rtl/vag_prio.sv
module vag_prio
    import vag_pkg::*;
#(
    parameter int N  = NRANK,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);
    logic [N-1:0] blocked;
    logic [N-1:0] hit;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g > 0) begin : g_chain
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
        if (g == N - 1) begin : g_default
            assign hit[g] = ~blocked[g];
        end else begin : g_normal
            assign hit[g] = req[g] & ~blocked[g];
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (hit[i]) idx = IW'(i);
    end
endmodule

// File: rtl/vag_addr.sv
module vag_addr
    import vag_pkg::*;
(
    input  pick_t pick,
    output addr_t hi_addr,
    output addr_t lo_addr
);
    logic [OFFW-1:0] off;

    always_comb begin
        off     = slot_offset(pick.rank);
        hi_addr = {pick.page, off};
        lo_addr = {pick.page, off | {{(OFFW-1){1'b0}}, 1'b1}};
    end
endmodule

// File: rtl/vag_fetch.sv
module vag_fetch
    import vag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  addr_t hi_addr,
    input  addr_t lo_addr,
    input  byte_t rd_data,
    output logic  load,
    output logic  rd_en,
    output addr_t rd_addr,
    output addr_t tgt,
    output logic  vld
);
    fetch_st_t        st;
    logic [DW-2:0]    hi_keep;

    assign load = (st == ST_IDLE) && go;

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        case (st)
            ST_HI: begin rd_en = 1'b1; rd_addr = hi_addr; end
            ST_LO: begin rd_en = 1'b1; rd_addr = lo_addr; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            hi_keep <= '0;
            tgt     <= '0;
            vld     <= 1'b0;
        end else begin
            vld <= 1'b0;
            case (st)
                ST_IDLE: if (go) st <= ST_HI;
                ST_HI:   st <= ST_LO;
                ST_LO: begin
                    hi_keep <= rd_data[DW-2:0];
                    st      <= ST_CAP;
                end
                ST_CAP: begin
                    tgt <= {hi_keep, rd_data};
                    vld <= 1'b1;
                    st  <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vag_top.sv
module vag_top
    import vag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_go,
    input  logic [NRANK-1:0]      req_act,
    input  logic [AW-1:0]         sel_pc,
    output logic                  rd_en,
    output logic [AW-1:0]         rd_addr,
    input  logic [DW-1:0]         rd_data,
    output logic [AW-1:0]         jump_tgt,
    output logic                  jump_vld
);
    rank_t win;
    pick_t pick_q;
    addr_t hi_addr, lo_addr;
    logic  load;

    vag_prio #(.N(NRANK)) u_prio (
        .req (req_act),
        .idx (win)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pick_q <= '0;
        else if (load)
            pick_q <= '{rank: win, page: table_page(sel_pc)};
    end

    vag_addr u_addr (
        .pick    (pick_q),
        .hi_addr (hi_addr),
        .lo_addr (lo_addr)
    );

    vag_fetch u_fetch (
        .clk     (clk),
        .rst     (rst),
        .go      (sel_go),
        .hi_addr (hi_addr),
        .lo_addr (lo_addr),
        .rd_data (rd_data),
        .load    (load),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .tgt     (jump_tgt),
        .vld     (jump_vld)
    );
endmodule

// File: rtl/vag_checker.sv
module vag_checker
    import vag_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NRANK-1:0] req_act,
    input logic [AW-1:0]    sel_pc,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [AW-1:0]    jump_tgt,
    input logic             jump_vld
);
    logic [NRANK-1:0] req_q;
    logic [AW-1:0]    pc_q;
    rank_t            k_seen;

    always_ff @(posedge clk) begin
        req_q <= req_act;
        pc_q  <= sel_pc;
    end

    assign k_seen = rank_t'((TOP_SLOT - rd_addr[OFFW-1:0]) >> 1);

    AST_TABLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr[OFFW-1:5] == 3'b111)); // R5

    AST_PAGE_PICK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr[0]) |-> (rd_addr[AW-1:OFFW] == table_page(pc_q))); // R6

    AST_NO_HIGHER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr[0]) |-> ((req_q & higher_mask(k_seen)) == '0)); // R2

    AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr[0]) |-> (k_seen == rank_t'(NRANK-1) || req_q[k_seen])); // R3

    AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_addr[0]) |=> (rd_en && rd_addr == $past(rd_addr) + AW'(1))); // R7

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        jump_vld |=> !jump_vld); // R9

    AST_VLD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(jump_vld) |-> ($past(rd_en, 2) && !$past(rd_en, 1))); // R9

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !jump_vld |-> $stable(jump_tgt)); // R10
endmodule

bind vag_top vag_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_act  (req_act),
    .sel_pc   (sel_pc),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .jump_tgt (jump_tgt),
    .jump_vld (jump_vld)
);

// File: tb/vag_top_bench.sv
module vag_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel_go;
    logic [15:0] req_act;
    logic [14:0] sel_pc;
    logic        rd_en;
    logic [14:0] rd_addr;
    logic [7:0]  rd_data;
    logic [14:0] jump_tgt;
    logic        jump_vld;

    int checks = 0;
    int bad    = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    vag_top u_vag_top (
        .clk(clk), .rst(rst), .sel_go(sel_go), .req_act(req_act),
        .sel_pc(sel_pc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .jump_tgt(jump_tgt), .jump_vld(jump_vld)
    );

    function automatic logic [7:0] romf(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], a[3]} ^ 8'h5A;
    endfunction

    always_ff @(posedge clk)
        if (rd_en) rd_data <= romf(rd_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_rank(input logic [15:0] r);
        for (int i = 0; i < 15; i++) if (r[i]) return i;
        return 15;
    endfunction

    // One selection; hold_go keeps sel_go high through the busy cycles (R10)
    task automatic do_sel(input logic [15:0] rq, input logic [14:0] pc,
                          input logic [15:0] rq_after, input bit hold_go,
                          input string tag);
        int          k;
        logic [6:0]  pg;
        logic [14:0] hi, lo, tgt;
        k   = ref_rank(rq);
        pg  = (pc[7:0] == 8'hFF) ? pc[14:8] + 7'd1 : pc[14:8];
        hi  = {pg, 8'hFE - 8'(2 * k)};
        lo  = hi + 15'd1;
        tgt = {romf(hi)[6:0], romf(lo)};
        @(negedge clk); sel_go = 1'b1; req_act = rq; sel_pc = pc;
        @(negedge clk); sel_go = hold_go; req_act = rq_after; sel_pc = ~pc;
        chk(rd_en === 1'b1 && rd_addr === hi, {tag, " R5 hi addr"}, int'(rd_addr), int'(hi));
        @(negedge clk);
        chk(rd_en === 1'b1 && rd_addr === lo, {tag, " R7 lo addr"}, int'(rd_addr), int'(lo));
        @(negedge clk);
        chk(rd_en === 1'b0 && jump_vld === 1'b0, {tag, " R9 gap cycle"}, int'(jump_vld), 0);
        @(negedge clk); sel_go = 1'b0;
        chk(jump_vld === 1'b1 && jump_tgt === tgt, {tag, " R8 target"}, int'(jump_tgt), int'(tgt));
        @(negedge clk);
        chk(jump_vld === 1'b0 && jump_tgt === tgt && rd_en === 1'b0,
            {tag, " R10 hold/no restart"}, int'(jump_tgt), int'(tgt));
    endtask

    task automatic t_reset();
        rst = 1'b1; sel_go = 1'b0; req_act = '0; sel_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(jump_vld === 1'b0 && rd_en === 1'b0 && jump_tgt === '0, "R1 in reset", int'(jump_tgt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(jump_vld === 1'b0 && rd_en === 1'b0 && jump_tgt === '0, "R1 after reset", int'(rd_en), 0);
    endtask

    task automatic t_priority();
        for (int i = 0; i < 15; i++)
            do_sel(16'(1) << i, 15'h1234, '0, 1'b0, "R2 one-hot");
        do_sel(16'hFFFF, 15'h0400, '0, 1'b0, "R2 software wins");
        do_sel(16'h8110, 15'h2A10, '0, 1'b0, "R2 mixed");
        for (int i = 0; i < 10; i++)
            do_sel(16'($urandom), 15'($urandom), 16'($urandom), 1'b0, "R2 random");
    endtask

    task automatic t_default();
        do_sel(16'h0000, 15'h0555, '0, 1'b0, "R3 none");
        do_sel(16'h8000, 15'h0555, '0, 1'b0, "R3 only bit15");
    endtask

    task automatic t_sample();
        do_sel(16'h0800, 15'h1100, 16'h0001, 1'b0, "R4 late higher");
        do_sel(16'h0004, 15'h1100, 16'h0000, 1'b0, "R4 drop after");
    endtask

    task automatic t_page_end();
        do_sel(16'h0002, 15'h03FF, '0, 1'b0, "R6 page end");
        do_sel(16'h0000, 15'h7FFF, '0, 1'b0, "R6 wrap");
        do_sel(16'h0001, 15'h03FE, '0, 1'b0, "R6 not end");
        do_sel(16'h0040, 15'h1F00, '0, 1'b0, "R5 page start");
    endtask

    task automatic t_msb();
        int seen = 0;
        for (int p = 0; p < 128; p++)
            if (romf({7'(p), 8'hFE})[7]) begin
                seen++;
                if (seen < 3) do_sel(16'h0001, {7'(p), 8'h10}, '0, 1'b0, "R8 msb drop");
            end
        chk(seen > 0, "R8 msb coverage", seen, 1);
    endtask

    task automatic t_busy();
        do_sel(16'h0020, 15'h2200, 16'h0001, 1'b1, "R10 go while busy");
    endtask

    initial begin
        #(8 * 100000);
        if (!ended) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_priority();
        t_default();
        t_sample();
        t_page_end();
        t_msb();
        t_busy();
        ended = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule